// File: doc/BRIEF.md
# Multi-Slot Peripheral Interrupt Collector

This block gathers interrupt sources from four peripheral slots of a power-management device. Each slot has eight source inputs and its own register bank. The bank decides, per source, whether the source is edge- or level-sensitive, and which polarity is active. It also holds an enable mask and a sticky event latch. A summary register has one bit per slot, and that bit is set while the slot holds any enabled, latched event. A single interrupt line is the OR of the summary bits.

The host reaches the block over a simple synchronous register port with 16-bit addresses and 8-bit data. A handler typically works in four steps. It reads the summary register to find the active slot. It then reads that slot's latched status. It acknowledges the events by writing ones to the slot's latched-clear register. It changes the enable mask only through separate write-one-to-set and write-one-to-clear registers, so a read-modify-write is never needed.

Source inputs are asynchronous. They pass through a synchronizer before detection, and detection compares the synchronized level with its value one cycle earlier.

Top module: `pirq_hub`

## Requirements
- R1: Slot banks decode at upper address bytes 0x09, 0x24, 0xC0 and 0xC1 for slots 0 to 3. Offsets within a bank are: live level 0x10, mode 0x11, active-high 0x12, active-low 0x13, acknowledge 0x14, enable-set 0x15, enable-clear 0x16, event latch 0x18. The summary register sits at 0x0550. Any other address reads 0x00, and writes to it change nothing.
- R2: The live-level register returns the source inputs of its slot after a two-flop synchronizer. Bit n of a slot is source input 8*slot+n.
- R3: When a mode bit is 0 (level mode), the event latch bit is set in every cycle in which the synchronized source is 1 with its active-high bit set, or is 0 with its active-low bit set.
- R4: When a mode bit is 1 (edge mode), the latch bit is set by a rising edge if the active-high bit is set, and by a falling edge if the active-low bit is set. With both bits set, either edge sets it.
- R5: A source whose active-high and active-low bits are both 0 never sets its latch bit, in either mode.
- R6: A 1 written to an enable-set bit enables that source, and a 1 written to an enable-clear bit disables it. Zero bits leave the mask unchanged. Both offsets read back the current enable mask.
- R7: A 1 written to an acknowledge bit clears the latch bit. Zero bits leave their latch bits alone. An event detected in the same cycle as the acknowledge keeps the bit set. The acknowledge offset reads 0x00.
- R8: Latch bits are sticky and are set regardless of the enable mask. Writes to the live-level, event-latch and summary addresses are ignored.
- R9: Summary bit n is 1 when slot n has a bit that is both latched and enabled. The interrupt output is 1 when any summary bit is 1.
- R10: Reset clears every mode, polarity, enable and latch bit, so the interrupt output is 0 and all configuration reads return 0x00.
- R11: Read data updates on the clock edge that samples a read request and holds its value through idle and write cycles.
- R12: The mode, active-high and active-low registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Raw source levels, slot s bit n at index 8*s+n |
| bus_en | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench first runs a directed test on one slot that sets up four sources as rise-only, fall-only, both-edge and no-polarity. It then applies one rising and one falling transition, which separates each edge rule from the others and from a polarity that was never armed. A level-mode source held active while it is acknowledged shows whether a same-cycle event beats the clear. Acknowledging the same bit after the source drops shows that the clear works once the source is inactive. Seeded random sequences follow: they mix source toggles, configuration and enable writes, acknowledges and reads across all slots. After each step a bench model predicts every register, the summary and the interrupt line, which exposes wrong slot decoding, polarity swaps and enable leakage.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int SLOTS    = 4;
    localparam int SRC_BITS = 8;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;

    localparam logic [15:0] SUMMARY_ADDR = 16'h0550;
    localparam logic [15:0] SLOT_BASE [SLOTS] = '{16'h0900, 16'h2400, 16'hC000, 16'hC100};

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LIVE,
        SEL_MODE,
        SEL_ACT_HI,
        SEL_ACT_LO,
        SEL_ACK,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_LATCH
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
        case (ofs)
            8'h10:   return SEL_LIVE;
            8'h11:   return SEL_MODE;
            8'h12:   return SEL_ACT_HI;
            8'h13:   return SEL_ACT_LO;
            8'h14:   return SEL_ACK;
            8'h15:   return SEL_EN_SET;
            8'h16:   return SEL_EN_CLR;
            8'h18:   return SEL_LATCH;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] mode_edge,
    input  logic [WIDTH-1:0] act_hi,
    input  logic [WIDTH-1:0] act_lo,
    output logic [WIDTH-1:0] hit
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic rise, fall, lvl;
        assign rise = cur[b] & ~prev[b] & act_hi[b];
        assign fall = ~cur[b] & prev[b] & act_lo[b];
        assign lvl  = (cur[b] & act_hi[b]) | (~cur[b] & act_lo[b]);
        assign hit[b] = mode_edge[b] ? (rise | fall) : lvl;
    end
endmodule

// File: rtl/pirq_slot.sv
module pirq_slot
    import pirq_pkg::*;
#(
    parameter int NSRC        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            wr_en,
    input  reg_sel_e        wr_sel,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] live,
    output logic [NSRC-1:0] mode_edge,
    output logic [NSRC-1:0] act_hi,
    output logic [NSRC-1:0] act_lo,
    output logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] latch,
    output logic            pending
);
    logic [NSRC-1:0] prev_live;
    logic [NSRC-1:0] det;
    logic [NSRC-1:0] ack_mask;
    logic [NSRC-1:0] latch_nxt;

    pirq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src),
        .q     (live)
    );

    pirq_detect #(.WIDTH(NSRC)) u_det (
        .cur       (live),
        .prev      (prev_live),
        .mode_edge (mode_edge),
        .act_hi    (act_hi),
        .act_lo    (act_lo),
        .hit       (det)
    );

    assign ack_mask  = (wr_en && wr_sel == SEL_ACK) ? wdata : '0;
    assign latch_nxt = (latch & ~ack_mask) | det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_live <= '0;
            mode_edge <= '0;
            act_hi    <= '0;
            act_lo    <= '0;
            enable    <= '0;
            latch     <= '0;
        end else begin
            prev_live <= live;
            latch     <= latch_nxt;
            if (wr_en) begin
                case (wr_sel)
                    SEL_MODE:   mode_edge <= wdata;
                    SEL_ACT_HI: act_hi    <= wdata;
                    SEL_ACT_LO: act_lo    <= wdata;
                    SEL_EN_SET: enable    <= enable | wdata;
                    SEL_EN_CLR: enable    <= enable & ~wdata;
                    default:    ;
                endcase
            end
        end
    end

    assign pending = |(latch & enable);

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_EN_SET) |=> ((enable & $past(wdata)) == $past(wdata))); // R6
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_EN_CLR) |=> ((enable & $past(wdata)) == '0)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask != '0) |=> ((latch & $past(ack_mask & ~det)) == '0)); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (det != '0) |=> ((latch & $past(det)) == $past(det))); // R7
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask == '0) |=> ((latch & $past(latch)) == $past(latch))); // R8
    AST_NO_POL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((det & ~(act_hi | act_lo)) == '0)); // R5
endmodule

// File: rtl/pirq_hub.sv
module pirq_hub
    import pirq_pkg::*;
#(
    parameter int NSLOT       = SLOTS,
    parameter int NSRC        = SRC_BITS,
    parameter int SYNC_STAGES = 2,
    localparam int SRC_W      = NSLOT * NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_in,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NSLOT-1:0] slot_hit;
    logic             sum_hit;
    reg_sel_e         sel;
    logic             mapped;
    logic [NSLOT-1:0] summary;
    logic [DATA_W-1:0] rd_val;

    logic [NSRC-1:0] live_a  [NSLOT];
    logic [NSRC-1:0] mode_a  [NSLOT];
    logic [NSRC-1:0] hi_a    [NSLOT];
    logic [NSRC-1:0] lo_a    [NSLOT];
    logic [NSRC-1:0] en_a    [NSLOT];
    logic [NSRC-1:0] lat_a   [NSLOT];

    assign sum_hit = (bus_addr == SUMMARY_ADDR);
    assign sel     = decode_offset(bus_addr[7:0]);
    assign mapped  = sum_hit || ((|slot_hit) && sel != SEL_NONE);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_hit[g] = (bus_addr[15:8] == SLOT_BASE[g][15:8]);

        pirq_slot #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_in[g*NSRC +: NSRC]),
            .wr_en     (bus_en && bus_we && slot_hit[g]),
            .wr_sel    (sel),
            .wdata     (bus_wdata[NSRC-1:0]),
            .live      (live_a[g]),
            .mode_edge (mode_a[g]),
            .act_hi    (hi_a[g]),
            .act_lo    (lo_a[g]),
            .enable    (en_a[g]),
            .latch     (lat_a[g]),
            .pending   (summary[g])
        );
    end

    always_comb begin
        rd_val = '0;
        if (sum_hit) begin
            rd_val = DATA_W'(summary);
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_hit[s]) begin
                case (sel)
                    SEL_LIVE:   rd_val = DATA_W'(live_a[s]);
                    SEL_MODE:   rd_val = DATA_W'(mode_a[s]);
                    SEL_ACT_HI: rd_val = DATA_W'(hi_a[s]);
                    SEL_ACT_LO: rd_val = DATA_W'(lo_a[s]);
                    SEL_EN_SET,
                    SEL_EN_CLR: rd_val = DATA_W'(en_a[s]);
                    SEL_LATCH:  rd_val = DATA_W'(lat_a[s]);
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            bus_rdata <= rd_val;
        end
    end

    assign irq_out = |summary;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !mapped) |=> (bus_rdata == '0)); // R1
    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit)); // R1
endmodule

// File: tb/tb_pirq_hub.sv
module tb_pirq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_out;

    always #10 clk = ~clk;

    pirq_hub dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_src [4];
    logic [7:0] m_mode [4];
    logic [7:0] m_hi [4];
    logic [7:0] m_lo [4];
    logic [7:0] m_en [4];
    logic [7:0] m_lat [4];

    function automatic logic [15:0] base_of(int s);
        case (s)
            0: return 16'h0900;
            1: return 16'h2400;
            2: return 16'hC000;
            default: return 16'hC100;
        endcase
    endfunction

    function automatic logic [7:0] lvl_hit(int s, logic [7:0] v);
        return ~m_mode[s] & ((v & m_hi[s]) | (~v & m_lo[s]));
    endfunction

    function automatic logic [7:0] edge_hit(int s, logic [7:0] o, logic [7:0] n);
        return m_mode[s] & ((n & ~o & m_hi[s]) | (~n & o & m_lo[s]));
    endfunction

    function automatic logic [7:0] exp_summary();
        logic [7:0] r = '0;
        for (int s = 0; s < 4; s++) r[s] = |(m_lat[s] & m_en[s]);
        return r;
    endfunction

    function automatic logic [7:0] exp_reg(int s, logic [7:0] ofs);
        case (ofs)
            8'h10: return m_src[s];
            8'h11: return m_mode[s];
            8'h12: return m_hi[s];
            8'h13: return m_lo[s];
            8'h15, 8'h16: return m_en[s];
            8'h18: return m_lat[s];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] ofs);
        case (ofs)
            8'h10: return "R2";
            8'h11, 8'h12, 8'h13: return "R12";
            8'h14: return "R7";
            8'h15, 8'h16: return "R6";
            8'h18: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic drive_src();
        for (int s = 0; s < 4; s++) src_in[s*8 +: 8] = m_src[s];
    endtask

    task automatic model_relevel();
        for (int s = 0; s < 4; s++) m_lat[s] = m_lat[s] | lvl_hit(s, m_src[s]);
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic reg_write(int s, logic [7:0] ofs, logic [7:0] d);
        bus_write(base_of(s) | 16'(ofs), d);
        case (ofs)
            8'h11: m_mode[s] = d;
            8'h12: m_hi[s] = d;
            8'h13: m_lo[s] = d;
            8'h14: m_lat[s] = m_lat[s] & ~d;
            8'h15: m_en[s] = m_en[s] | d;
            8'h16: m_en[s] = m_en[s] & ~d;
            default: ;
        endcase
        model_relevel();
    endtask

    task automatic set_src(int s, logic [7:0] v);
        logic [7:0] old = m_src[s];
        @(negedge clk);
        m_src[s] = v;
        drive_src();
        repeat (4) @(negedge clk);
        m_lat[s] = m_lat[s] | edge_hit(s, old, v) | lvl_hit(s, v);
    endtask

    task automatic check_reg(int s, logic [7:0] ofs, string tag);
        logic [7:0] d;
        bus_read(base_of(s) | 16'(ofs), d);
        chk(tag, d, exp_reg(s, ofs));
    endtask

    task automatic check_sum(string tag);
        logic [7:0] d;
        bus_read(16'h0550, d);
        chk(tag, d, exp_summary());
        chk(tag, {7'b0, irq_out}, {7'b0, |exp_summary()});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        for (int s = 0; s < 4; s++) begin
            m_mode[s] = '0; m_hi[s] = '0; m_lo[s] = '0; m_en[s] = '0; m_lat[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d, held;
        for (int s = 0; s < 4; s++) m_src[s] = '0;
        void'($urandom(32'h5EED));
        do_reset();

        // R10: reset state
        chk("R10", {7'b0, irq_out}, 8'h00);
        for (int s = 0; s < 4; s++) begin
            check_reg(s, 8'h11, "R10");
            check_reg(s, 8'h15, "R10");
            check_reg(s, 8'h18, "R10");
        end

        // R1: unmapped addresses
        bus_read(16'h0000, d); chk("R1", d, 8'h00);
        bus_read(16'h0917, d); chk("R1", d, 8'h00);
        bus_write(16'h0917, 8'hFF);
        bus_write(16'h0551, 8'hFF);
        check_reg(0, 8'h15, "R1");
        check_reg(0, 8'h11, "R1");

        // R4/R5: edge rules on slot 1
        reg_write(1, 8'h11, 8'h0F);
        reg_write(1, 8'h12, 8'h05);
        reg_write(1, 8'h13, 8'h06);
        set_src(1, 8'h0F);
        bus_read(16'h2418, d); chk("R4", d, 8'h05);
        reg_write(1, 8'h14, 8'hFF);
        set_src(1, 8'h00);
        bus_read(16'h2418, d); chk("R4", d, 8'h06);
        chk("R5", d & 8'h08, 8'h00);
        chk("R9", {7'b0, irq_out}, 8'h00);

        // R9: enable one latched bit
        reg_write(1, 8'h15, 8'h02);
        check_sum("R9");
        bus_read(16'h0550, d); chk("R9", d, 8'h02);
        reg_write(1, 8'h15, 8'h00);
        check_reg(1, 8'h15, "R6");
        reg_write(1, 8'h16, 8'h02);
        check_sum("R9");
        check_reg(1, 8'h18, "R8");

        // R8: writes to read-only offsets ignored
        bus_write(16'h2418, 8'h00);
        bus_write(16'h2410, 8'hFF);
        check_reg(1, 8'h18, "R8");
        check_reg(1, 8'h10, "R8");

        // R3/R7: level mode event wins over acknowledge
        reg_write(2, 8'h12, 8'h01);
        set_src(2, 8'h01);
        check_reg(2, 8'h18, "R3");
        reg_write(2, 8'h14, 8'h01);
        bus_read(16'hC018, d); chk("R7", d, 8'h01);
        set_src(2, 8'h00);
        check_reg(2, 8'h18, "R8");
        reg_write(2, 8'h14, 8'h01);
        bus_read(16'hC018, d); chk("R7", d, 8'h00);
        check_reg(2, 8'h14, "R7");

        // R11: read data holds through idle and writes
        bus_read(16'hC012, held);
        repeat (2) @(negedge clk);
        chk("R11", bus_rdata, held);
        bus_write(16'hC013, 8'h00);
        chk("R11", bus_rdata, held);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int s = $urandom_range(0, 3);
            int op = $urandom_range(0, 7);
            logic [7:0] v = 8'($urandom);
            case (op)
                0, 1: set_src(s, v);
                2: reg_write(s, 8'h11, v);
                3: reg_write(s, 8'($urandom_range(8'h12, 8'h13)), v);
                4: reg_write(s, 8'($urandom_range(8'h14, 8'h16)), v);
                5: check_sum("R9");
                default: begin
                    logic [7:0] ofs = 8'($urandom_range(8'h10, 8'h18));
                    check_reg(s, ofs, tag_of(ofs));
                end
            endcase
            chk("R9", {7'b0, irq_out}, {7'b0, |exp_summary()});
        end

        // R10: reset mid-run
        do_reset();
        chk("R10", {7'b0, irq_out}, 8'h00);
        for (int s = 0; s < 4; s++) begin
            check_reg(s, 8'h12, "R10");
            check_reg(s, 8'h16, "R10");
            check_reg(s, 8'h18, "R10");
        end
        check_reg(3, 8'h10, "R2");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule